// File: doc/BRIEF.md
# Atomic Access Permission Checker

This block decides whether an atomic access may go ahead. The access is either a conditional store or an exclusive access. It sits beside the load/store pipeline. An external translation unit has already looked up the page, and it supplies the read and write permission bits, a translation fault code and the cache attribute of the page. The block combines these with a 6-bit atomic-control register and a flag that says whether a data cache is built in. From them it produces an exception flag, a cause code and the faulting virtual address, which goes to the cause-address register.

The atomic-control register holds three 2-bit fields, one for each cacheable kind of page. The page attribute selects one field. A zero field means that atomics are not supported on that kind of page, and the access traps. Isolate pages always trap. When there is no data cache, the bypass field governs every access. A translation fault takes precedence over all other checks. For a conditional store, a page without both read and write permission traps next. The result is registered, and it appears one cycle after the request strobe.

Top module: `atomic_perm_check`

## Requirements
- R1: While `rst` is high at a clock edge, `exc_valid` and `rsp_done` become 0 and `exc_cause` becomes 0.
- R2: `rsp_done` is 1 in exactly the cycle after a cycle with `req_valid` high. When `req_valid` is low, `exc_valid` is 0 in the next cycle.
- R3: With a data cache present, attribute code 0 (bypass) selects `atomic_ctrl[1:0]`, code 1 (write-through) selects `atomic_ctrl[3:2]` and code 2 (write-back) selects `atomic_ctrl[5:4]`. A nonzero selected field raises no exception.
- R4: A zero selected field on a conditional store (`kind_excl`=0) raises an exception with cause `CAUSE_LDST` (default 3).
- R5: A zero selected field on an exclusive access (`kind_excl`=1) raises an exception with cause `CAUSE_EXCL` (default 7).
- R6: With a data cache present, attribute code 3 (isolate) raises cause `CAUSE_LDST` for both access kinds, whatever `atomic_ctrl` holds.
- R7: With a data cache present, attribute codes 4 to 7 never raise an exception. In that case `exc_cause` reads 0.
- R8: When `dcache_present` is 0, the attribute is ignored and `atomic_ctrl[1:0]` decides. This applies to isolate pages as well.
- R9: A conditional store to a page where `perm_rd` and `perm_wr` are not both 1 raises cause `CAUSE_STPROH` (default 29). This check comes before the attribute checks. Exclusive accesses are not subject to it.
- R10: A nonzero `xlate_fault` is reported as the cause and takes priority over every other check.
- R11: Each strobed request loads its `vaddr` into `exc_vaddr`, which is presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one check per high cycle |
| kind_excl | input | 1 | 0 = conditional store, 1 = exclusive access |
| perm_rd | input | 1 | Page is readable |
| perm_wr | input | 1 | Page is writable |
| xlate_fault | input | 6 | Translation fault code, 0 = no fault |
| cache_attr | input | 3 | 0 bypass, 1 write-through, 2 write-back, 3 isolate, 4-7 other |
| atomic_ctrl | input | 6 | Atomic-control register, three 2-bit fields |
| dcache_present | input | 1 | A data cache is configured |
| vaddr | input | 32 | Virtual address of the access |
| exc_valid | output | 1 | Exception raised by the last request |
| exc_cause | output | 6 | Cause code (0 when no exception) |
| exc_vaddr | output | 32 | Address of the last request |
| rsp_done | output | 1 | A check result is presented this cycle |

## Verification
The assertions assume that `rst` is high from the first clock edge. They also assume that every request input is settled whenever `req_valid` is high, and that the three cause parameters are distinct and nonzero. Their output checks relate each registered result to the request inputs one cycle earlier. For that reason, translation fault codes are driven only as values that fit the cause width. The stimulus changes inputs only on falling edges and issues one request at a time. It always drops the strobe before a new scenario, so every result can be traced to a single request.

// File: rtl/atomchk_pkg.sv
package atomchk_pkg;

    localparam int CTRL_FIELDS = 3;
    localparam int FIELD_W     = 2;
    localparam int CTRL_W      = CTRL_FIELDS * FIELD_W;
    localparam int ATTR_W      = 3;
    localparam int CAUSE_W     = 6;
    localparam int ADDR_W      = 32;

    localparam logic [ATTR_W-1:0] ATTR_BYPASS  = 3'd0;
    localparam logic [ATTR_W-1:0] ATTR_WTHRU   = 3'd1;
    localparam logic [ATTR_W-1:0] ATTR_WBACK   = 3'd2;
    localparam logic [ATTR_W-1:0] ATTR_ISOLATE = 3'd3;

    typedef enum logic {
        KIND_CSTORE = 1'b0,
        KIND_EXCL   = 1'b1
    } acc_kind_e;

    typedef struct packed {
        logic               raise;
        logic [CAUSE_W-1:0] cause;
    } chk_result_t;

    function automatic logic field_blocks(input logic [FIELD_W-1:0] f);
        return (f == '0);
    endfunction

endpackage

// File: rtl/atomchk_fieldsel.sv
module atomchk_fieldsel
    import atomchk_pkg::*;
(
    input  logic [CTRL_W-1:0]  ctrl,
    input  logic [ATTR_W-1:0]  attr,
    input  logic               dcache_present,
    output logic [FIELD_W-1:0] field,
    output logic               use_field,
    output logic               isolate
);

    logic [FIELD_W-1:0] fld [CTRL_FIELDS];
    logic [ATTR_W-1:0]  eff_attr;

    generate
        for (genvar g = 0; g < CTRL_FIELDS; g++) begin : g_fld
            assign fld[g] = ctrl[g*FIELD_W +: FIELD_W];
        end
    endgenerate

    always_comb begin
        eff_attr  = dcache_present ? attr : ATTR_BYPASS;
        field     = '0;
        use_field = 1'b0;
        isolate   = 1'b0;
        case (eff_attr)
            ATTR_BYPASS: begin
                use_field = 1'b1;
                field     = fld[0];
            end
            ATTR_WTHRU: begin
                use_field = 1'b1;
                field     = fld[1];
            end
            ATTR_WBACK: begin
                use_field = 1'b1;
                field     = fld[2];
            end
            ATTR_ISOLATE: isolate = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/atomchk_decide.sv
module atomchk_decide
    import atomchk_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] CAUSE_LDST   = 6'd3,
    parameter logic [CAUSE_W-1:0] CAUSE_EXCL   = 6'd7,
    parameter logic [CAUSE_W-1:0] CAUSE_STPROH = 6'd29
) (
    input  logic [CAUSE_W-1:0] fault,
    input  acc_kind_e          kind,
    input  logic               perm_rd,
    input  logic               perm_wr,
    input  logic               use_field,
    input  logic [FIELD_W-1:0] field,
    input  logic               isolate,
    output chk_result_t        res
);

    always_comb begin
        res = '0;
        if (fault != '0) begin
            res.raise = 1'b1;
            res.cause = fault;
        end else if (kind == KIND_CSTORE && !(perm_rd && perm_wr)) begin
            res.raise = 1'b1;
            res.cause = CAUSE_STPROH;
        end else if (isolate) begin
            res.raise = 1'b1;
            res.cause = CAUSE_LDST;
        end else if (use_field && field_blocks(field)) begin
            res.raise = 1'b1;
            res.cause = (kind == KIND_EXCL) ? CAUSE_EXCL : CAUSE_LDST;
        end
    end

endmodule

// File: rtl/atomic_perm_check.sv
module atomic_perm_check
    import atomchk_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] CAUSE_LDST   = 6'd3,
    parameter logic [CAUSE_W-1:0] CAUSE_EXCL   = 6'd7,
    parameter logic [CAUSE_W-1:0] CAUSE_STPROH = 6'd29
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               kind_excl,
    input  logic               perm_rd,
    input  logic               perm_wr,
    input  logic [CAUSE_W-1:0] xlate_fault,
    input  logic [ATTR_W-1:0]  cache_attr,
    input  logic [CTRL_W-1:0]  atomic_ctrl,
    input  logic               dcache_present,
    input  logic [ADDR_W-1:0]  vaddr,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [ADDR_W-1:0]  exc_vaddr,
    output logic               rsp_done
);

    logic [FIELD_W-1:0] sel_field;
    logic               sel_use;
    logic               sel_iso;
    chk_result_t        verdict;
    acc_kind_e          kind;

    assign kind = kind_excl ? KIND_EXCL : KIND_CSTORE;

    atomchk_fieldsel u_sel (
        .ctrl           (atomic_ctrl),
        .attr           (cache_attr),
        .dcache_present (dcache_present),
        .field          (sel_field),
        .use_field      (sel_use),
        .isolate        (sel_iso)
    );

    atomchk_decide #(
        .CAUSE_LDST   (CAUSE_LDST),
        .CAUSE_EXCL   (CAUSE_EXCL),
        .CAUSE_STPROH (CAUSE_STPROH)
    ) u_dec (
        .fault     (xlate_fault),
        .kind      (kind),
        .perm_rd   (perm_rd),
        .perm_wr   (perm_wr),
        .use_field (sel_use),
        .field     (sel_field),
        .isolate   (sel_iso),
        .res       (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            exc_valid <= 1'b0;
            exc_cause <= '0;
            exc_vaddr <= '0;
        end else begin
            rsp_done  <= req_valid;
            exc_valid <= req_valid && verdict.raise;
            if (req_valid) begin
                exc_cause <= verdict.raise ? verdict.cause : '0;
                exc_vaddr <= vaddr;
            end
        end
    end

    // R2
    done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done);

    // R2
    idle_no_exc_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!exc_valid && !rsp_done));

    // R10
    fault_first_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && xlate_fault != '0) |=> (exc_valid && exc_cause == $past(xlate_fault)));

    // R6
    isolate_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dcache_present && cache_attr == ATTR_ISOLATE && xlate_fault == '0
         && (kind_excl || (perm_rd && perm_wr))) |=> (exc_valid && exc_cause == CAUSE_LDST));

    // R7
    other_attr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dcache_present && cache_attr[2] && xlate_fault == '0
         && perm_rd && perm_wr) |=> !exc_valid);

    // R9
    rw_perm_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !kind_excl && xlate_fault == '0 && !(perm_rd && perm_wr))
        |=> (exc_valid && exc_cause == CAUSE_STPROH));

    // R11
    vaddr_pass_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (exc_vaddr == $past(vaddr)));

endmodule

// File: tb/atomic_perm_check_test.sv
module atomic_perm_check_test;
    import atomchk_pkg::*;

    localparam int CLK_P = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               kind_excl = 1'b0;
    logic               perm_rd = 1'b1;
    logic               perm_wr = 1'b1;
    logic [CAUSE_W-1:0] xlate_fault = '0;
    logic [ATTR_W-1:0]  cache_attr = '0;
    logic [CTRL_W-1:0]  atomic_ctrl = '0;
    logic               dcache_present = 1'b1;
    logic [ADDR_W-1:0]  vaddr = '0;
    logic               exc_valid;
    logic [CAUSE_W-1:0] exc_cause;
    logic [ADDR_W-1:0]  exc_vaddr;
    logic               rsp_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    atomic_perm_check uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .kind_excl(kind_excl),
        .perm_rd(perm_rd), .perm_wr(perm_wr), .xlate_fault(xlate_fault),
        .cache_attr(cache_attr), .atomic_ctrl(atomic_ctrl),
        .dcache_present(dcache_present), .vaddr(vaddr),
        .exc_valid(exc_valid), .exc_cause(exc_cause),
        .exc_vaddr(exc_vaddr), .rsp_done(rsp_done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one strobed request; returns at the falling edge after the capture edge
    task automatic issue(input logic ex, input logic rd, input logic wr,
                         input logic [CAUSE_W-1:0] flt, input logic [ATTR_W-1:0] at,
                         input logic [CTRL_W-1:0] ct, input logic dc,
                         input logic [ADDR_W-1:0] va);
        @(negedge clk);
        kind_excl = ex; perm_rd = rd; perm_wr = wr; xlate_fault = flt;
        cache_attr = at; atomic_ctrl = ct; dcache_present = dc; vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic v, input logic [CAUSE_W-1:0] c);
        chk({tag, " valid"}, 64'(exc_valid), 64'(v));
        chk({tag, " cause"}, 64'(exc_cause), 64'(c));
    endtask

    task automatic t_reset();
        // R1: outputs cleared while reset held
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid", 64'(exc_valid), 64'd0);
        chk("R1 done", 64'(rsp_done), 64'd0);
        chk("R1 cause", 64'(exc_cause), 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_latency();
        issue(0, 1, 1, 0, 0, 6'b000000, 1, 32'h10);
        chk("R2 done after strobe", 64'(rsp_done), 64'd1);
        chk("R2 raise", 64'(exc_valid), 64'd1);
        @(negedge clk);
        chk("R2 done idle", 64'(rsp_done), 64'd0);
        chk("R2 valid idle", 64'(exc_valid), 64'd0);
    endtask

    task automatic t_fields();
        issue(0, 1, 1, 0, 0, 6'b010101, 1, 32'h0); expect_res("R3 bypass ok", 0, 0);
        issue(0, 1, 1, 0, 1, 6'b010101, 1, 32'h0); expect_res("R3 wthru ok", 0, 0);
        issue(0, 1, 1, 0, 2, 6'b010101, 1, 32'h0); expect_res("R3 wback ok", 0, 0);
        issue(0, 1, 1, 0, 0, 6'b000001, 1, 32'h0); expect_res("R3 bypass sel", 0, 0);
        issue(0, 1, 1, 0, 1, 6'b000001, 1, 32'h0); expect_res("R3 wthru sel", 1, 3);
        issue(0, 1, 1, 0, 2, 6'b110000, 1, 32'h0); expect_res("R3 wback sel", 0, 0);
        issue(0, 1, 1, 0, 0, 6'b110000, 1, 32'h0); expect_res("R3 bypass zero", 1, 3);
    endtask

    task automatic t_zero_cstore();
        issue(0, 1, 1, 0, 1, 6'b110011, 1, 32'h0); expect_res("R4 cstore zero", 1, 3);
    endtask

    task automatic t_zero_excl();
        issue(1, 1, 1, 0, 2, 6'b001111, 1, 32'h0); expect_res("R5 excl wback zero", 1, 7);
        issue(1, 1, 1, 0, 0, 6'b111100, 1, 32'h0); expect_res("R5 excl bypass zero", 1, 7);
        issue(1, 1, 1, 0, 0, 6'b000010, 1, 32'h0); expect_res("R5 excl nonzero", 0, 0);
    endtask

    task automatic t_isolate();
        issue(0, 1, 1, 0, 3, 6'b111111, 1, 32'h0); expect_res("R6 isolate cstore", 1, 3);
        issue(1, 1, 1, 0, 3, 6'b111111, 1, 32'h0); expect_res("R6 isolate excl", 1, 3);
    endtask

    task automatic t_other();
        for (int a = 4; a < 8; a++) begin
            issue(a[0], 1, 1, 0, 3'(a), 6'b000000, 1, 32'h0);
            expect_res("R7 other attr", 0, 0);
        end
    endtask

    task automatic t_nodcache();
        issue(0, 1, 1, 0, 3, 6'b000010, 0, 32'h0); expect_res("R8 isolate ignored", 0, 0);
        issue(0, 1, 1, 0, 2, 6'b110000, 0, 32'h0); expect_res("R8 wback uses bypass", 1, 3);
        issue(1, 1, 1, 0, 5, 6'b111100, 0, 32'h0); expect_res("R8 other uses bypass", 1, 7);
    endtask

    task automatic t_rwperm();
        issue(0, 1, 0, 0, 0, 6'b111111, 1, 32'h0); expect_res("R9 no write", 1, 29);
        issue(0, 0, 1, 0, 0, 6'b111111, 1, 32'h0); expect_res("R9 no read", 1, 29);
        issue(0, 0, 1, 0, 3, 6'b111111, 1, 32'h0); expect_res("R9 before isolate", 1, 29);
        issue(1, 0, 0, 0, 0, 6'b111111, 1, 32'h0); expect_res("R9 excl exempt", 0, 0);
    endtask

    task automatic t_fault();
        issue(0, 0, 0, 6'd12, 3, 6'b000000, 1, 32'h0); expect_res("R10 fault over perm", 1, 12);
        issue(1, 1, 1, 6'd2, 0, 6'b000000, 1, 32'h0); expect_res("R10 fault over field", 1, 2);
    endtask

    task automatic t_vaddr();
        issue(0, 1, 1, 0, 0, 6'b111111, 1, 32'hDEAD_BEEF);
        chk("R11 vaddr a", 64'(exc_vaddr), 64'hDEAD_BEEF);
        issue(1, 1, 1, 0, 0, 6'b000000, 1, 32'h0000_1234);
        chk("R11 vaddr b", 64'(exc_vaddr), 64'h0000_1234);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_fields();
        t_zero_cstore();
        t_zero_excl();
        t_isolate();
        t_other();
        t_nodcache();
        t_rwperm();
        t_fault();
        t_vaddr();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #(CLK_P * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule